// File: doc/BRIEF.md
# Buffered Zero-Overhead Loop Sequencer

This block sits beside a program sequencer and runs a block of instructions a programmed number of times with no branch overhead. A loop-start command, issued while the PC sits on the repeat instruction, names the last address of the body and a repeat count. The body begins at the following address. On the first pass the body is fetched from program memory, and each word is written into a small local instruction buffer at the same time. When the PC reaches the last address with repeats remaining, the block overrides the next PC with the body's first address. If the whole body fitted in the buffer and was captured from its first word, all later passes are served from the buffer, and program-memory reads are switched off.

Loops nest. A loop-start command issued inside a running loop saves the enclosing loop's first address, last address, remaining count and active flag on a small hardware stack. The enclosing loop is restored when the inner loop finishes. Explicit save and restore commands push and pop the same state, for nesting patterns that the automatic save cannot express. A restored loop carries on fetching from memory and refills the buffer on its next pass, because the inner loop has overwritten the buffer. A body longer than the buffer is fetched from memory on every pass. The result is still correct, but no power is saved.

Top module: `loop_buf_ctrl`

## Requirements
- R1: With no loop active, `mem_en_o` is 1, `src_buf_o` is 0 and `npc_ovr_o` is 0.
- R2: A loop-start command with count C and end address E, given while `pc_i` is P, runs every address P+1..E exactly C+1 times. Execution then continues at E+1 with no loop active.
- R3: When `pc_i` equals the active loop's end address and the remaining count is nonzero, `npc_ovr_o` is 1 and `npc_o` is the body's first address. The count then drops by one.
- R4: If the body length E-P is at most DEPTH, every pass after the first has `src_buf_o` 1 and `mem_en_o` 0. In those passes `buf_insn_o` equals the memory word at `pc_i`.
- R5: If the body length exceeds DEPTH, every pass has `mem_en_o` 1 and `src_buf_o` 0.
- R6: A loop-start command issued inside an active loop saves the outer loop. When the inner loop's count is exhausted at its end address, the outer loop is restored. The outer loop's remaining body and later passes then run from memory until a pass is captured whole.
- R7: A loop-start command issued while a loop is active and NEST loops are already saved is ignored.
- R8: An explicit push saves the active loop state, and an explicit pop restores it. A restored loop runs its next pass from memory and only then replays from the buffer.
- R9: A pop with an empty stack is ignored, and the running loop is unaffected.
- R10: Priority is start over push over pop. Any accepted command in a cycle suppresses that cycle's end-of-body handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | PC_W | Address being fetched this cycle |
| start_i | input | 1 | Loop-start command (pc_i is the repeat instruction) |
| start_cnt_i | input | CNT_W | Repeats minus one |
| start_end_i | input | PC_W | Last address of the body |
| push_i | input | 1 | Save active loop state on the stack |
| pop_i | input | 1 | Restore loop state from the stack |
| mem_insn_i | input | INSN_W | Word read from program memory at pc_i |
| npc_ovr_o | output | 1 | Replace the next PC with npc_o |
| npc_o | output | PC_W | First address of the active body |
| mem_en_o | output | 1 | Program-memory read enable |
| src_buf_o | output | 1 | Take the instruction from buf_insn_o |
| buf_insn_o | output | INSN_W | Buffered word for pc_i |

## Verification
The outputs `npc_ovr_o`, `mem_en_o`, `src_buf_o` and `buf_insn_o` are combinational from the current state and `pc_i`, so they are due in the same cycle as the PC they answer. A command takes effect at the next clock edge, so its result appears with the next PC. The bench therefore drives a command at the falling edge while the PC it belongs to is present. It samples the outputs at each following falling edge, after the edge that moved the PC, and counts per-address executions and buffered cycles for each run. It sweeps body lengths across the buffer-size boundary and every small count. It then runs the nesting, stack-full, explicit push/pop and empty-pop cases, each with counts worked out by hand from the requirements.

// File: rtl/loop_buf_ctrl.sv
module loop_buf_ctrl #(
  parameter int PC_W   = 12,
  parameter int INSN_W = 24,
  parameter int CNT_W  = 10,
  parameter int DEPTH  = 16,
  parameter int NEST   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic [PC_W-1:0]   start_end_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [INSN_W-1:0] mem_insn_i,
  output logic              npc_ovr_o,
  output logic [PC_W-1:0]   npc_o,
  output logic              mem_en_o,
  output logic              src_buf_o,
  output logic [INSN_W-1:0] buf_insn_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SP_W  = $clog2(NEST + 1);
  localparam int ENT_W = 1 + 2 * PC_W + CNT_W;

  typedef enum logic [1:0] {IDLE, FILL, REPLAY} st_t;

  st_t               st_q;
  logic              cap_q;
  logic [PC_W-1:0]   rsa_q, rea_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SP_W-1:0]   sp_q;
  logic [ENT_W-1:0]  stk_q [NEST];
  logic [INSN_W-1:0] buf_q [DEPTH];

  logic              active, full, empty, at_end, fits;
  logic              do_start, do_push, do_pop, any_cmd, wrap, done, restore, save;
  logic [PC_W-1:0]   off;
  logic [SP_W-1:0]   top_idx;
  logic              t_act;
  logic [PC_W-1:0]   t_rsa, t_rea;
  logic [CNT_W-1:0]  t_cnt;

  assign active   = st_q != IDLE;
  assign full     = sp_q == SP_W'(NEST);
  assign empty    = sp_q == '0;
  assign at_end   = active && pc_i == rea_q;
  assign off      = pc_i - rsa_q;
  assign fits     = (rea_q - rsa_q) < PC_W'(DEPTH);

  assign do_start = start_i && !(active && full);
  assign do_push  = push_i && !start_i && !full;
  assign do_pop   = pop_i && !start_i && !push_i && !empty;
  assign any_cmd  = do_start || do_push || do_pop;
  assign wrap     = at_end && !any_cmd && cnt_q != '0;
  assign done     = at_end && !any_cmd && cnt_q == '0;
  assign restore  = do_pop || (done && !empty);
  assign save     = (do_start && active) || do_push;

  assign top_idx  = sp_q - SP_W'(1);
  assign {t_act, t_rsa, t_rea, t_cnt} = stk_q[top_idx];

  assign npc_ovr_o  = wrap;
  assign npc_o      = rsa_q;
  assign src_buf_o  = st_q == REPLAY;
  assign mem_en_o   = !src_buf_o;
  assign buf_insn_o = buf_q[off[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= IDLE;
      cap_q <= 1'b0;
      rsa_q <= '0;
      rea_q <= '0;
      cnt_q <= '0;
      sp_q  <= '0;
    end else if (do_start) begin
      if (active) sp_q <= sp_q + SP_W'(1);
      rsa_q <= pc_i + PC_W'(1);
      rea_q <= start_end_i;
      cnt_q <= start_cnt_i;
      st_q  <= FILL;
      cap_q <= 1'b1;
    end else if (do_push) begin
      sp_q <= sp_q + SP_W'(1);
    end else if (restore) begin
      rsa_q <= t_rsa;
      rea_q <= t_rea;
      cnt_q <= t_cnt;
      st_q  <= t_act ? FILL : IDLE;
      cap_q <= 1'b0;
      sp_q  <= top_idx;
    end else if (done) begin
      st_q  <= IDLE;
      cap_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= cnt_q - CNT_W'(1);
      st_q  <= (st_q == REPLAY || (cap_q && fits)) ? REPLAY : FILL;
      cap_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NEST; i++)
      if (save && sp_q == SP_W'(i))
        stk_q[i] <= {active, rsa_q, rea_q, cnt_q};
  end

  always_ff @(posedge clk) begin
    if (st_q == FILL && cap_q && fits && off < PC_W'(DEPTH))
      buf_q[off[IDX_W-1:0]] <= mem_insn_i;
  end
endmodule

module loop_buf_chk #(
  parameter int PC_W  = 12,
  parameter int CNT_W = 10,
  parameter int DEPTH = 16,
  parameter int NEST  = 3,
  parameter int SP_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  pc_i,
  input logic             npc_ovr_o,
  input logic             src_buf_o,
  input logic [PC_W-1:0]  rsa_q,
  input logic [PC_W-1:0]  rea_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [SP_W-1:0]  sp_q
);
  // R3
  wrap_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npc_ovr_o |-> pc_i == rea_q);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npc_ovr_o |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R4
  replay_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_buf_o) |-> $past(npc_ovr_o));
  // R4
  replay_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_buf_o |-> (pc_i - rsa_q) < PC_W'(DEPTH));
  // R7
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(NEST));
endmodule

bind loop_buf_ctrl loop_buf_chk #(
  .PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .NEST(NEST), .SP_W(SP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .npc_ovr_o(npc_ovr_o),
  .src_buf_o(src_buf_o), .rsa_q(rsa_q), .rea_q(rea_q), .cnt_q(cnt_q),
  .sp_q(sp_q)
);

// File: tb/sim_loop_buf_ctrl.sv
module sim_loop_buf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8, INSN_W = 16, CNT_W = 4, DEPTH = 4, NEST = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [PC_W-1:0]   pc = '0, ldv = '0, start_end = '0, npc;
  logic              ld = 1'b0, start_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [CNT_W-1:0]  start_cnt = '0;
  logic [INSN_W-1:0] mem_insn, buf_insn;
  logic              npc_ovr, mem_en, src_buf;

  function automatic logic [INSN_W-1:0] ins(input logic [PC_W-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction
  assign mem_insn = ins(pc);

  always @(posedge clk) pc <= ld ? ldv : (npc_ovr ? npc : pc + 8'd1);

  loop_buf_ctrl #(.PC_W(PC_W), .INSN_W(INSN_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .NEST(NEST)) u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .start_i(start_i), .start_cnt_i(start_cnt),
    .start_end_i(start_end), .push_i(push_i), .pop_i(pop_i), .mem_insn_i(mem_insn),
    .npc_ovr_o(npc_ovr), .npc_o(npc), .mem_en_o(mem_en), .src_buf_o(src_buf),
    .buf_insn_o(buf_insn));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int ev_pc[4], ev_kind[4], ev_end[4], ev_cnt[4];
  bit ev_once[4], ev_done[4];
  int nev = 0;
  int hits[256];
  int nbuf, nbad;
  bit timed_out;

  task automatic exec(input int p, input int e, input int c, input int exitpc);
    for (int i = 0; i < 256; i++) hits[i] = 0;
    for (int i = 0; i < 4; i++) ev_done[i] = 1'b0;
    nbuf = 0; nbad = 0;
    @(negedge clk); ld = 1'b1; ldv = p[7:0];
    @(negedge clk); ld = 1'b0;
    start_i = 1'b1; start_cnt = c[3:0]; start_end = e[7:0];
    timed_out = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      start_i = 1'b0; push_i = 1'b0; pop_i = 1'b0;
      if (int'(pc) == exitpc) begin timed_out = 1'b0; break; end
      hits[pc]++;
      if (src_buf) begin
        nbuf++;
        if (buf_insn != ins(pc) || mem_en) nbad++;
      end else if (!mem_en) nbad++;
      for (int i = 0; i < nev; i++)
        if (ev_pc[i] == int'(pc) && !(ev_once[i] && ev_done[i])) begin
          ev_done[i] = 1'b1;
          case (ev_kind[i])
            1: begin start_i = 1'b1; start_cnt = ev_cnt[i][3:0]; start_end = ev_end[i][7:0]; end
            2: push_i = 1'b1;
            default: pop_i = 1'b1;
          endcase
        end
    end
    chk(!timed_out, "R2 exit address reached", int'(pc), exitpc);
    chk(mem_en && !src_buf && !npc_ovr, "R1 idle after loop", {mem_en, src_buf, npc_ovr}, 4);
  endtask

  task automatic add_ev(input int p, input int kind, input int e, input int c, input bit once);
    ev_pc[nev] = p; ev_kind[nev] = kind; ev_end[nev] = e; ev_cnt[nev] = c; ev_once[nev] = once;
    nev++;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_en == 1'b1, "R1 reset mem_en", mem_en, 1);
    chk(src_buf == 1'b0, "R1 reset src_buf", src_buf, 0);
    chk(npc_ovr == 1'b0, "R1 reset npc_ovr", npc_ovr, 0);

    // R2 R3 R4 R5: sweep body length across the buffer size and all small counts
    for (int len = 1; len <= 6; len++)
      for (int c = 0; c <= 3; c++) begin
        int expb;
        nev = 0;
        exec(8, 8 + len, c, 9 + len);
        expb = (len <= DEPTH) ? c * len : 0;
        chk(hits[8 + len] == c + 1, "R2 last address passes", hits[8 + len], c + 1);
        chk(hits[9] == c + 1, "R3 first address passes", hits[9], c + 1);
        chk(nbuf == expb, (len <= DEPTH) ? "R4 buffered cycles" : "R5 buffered cycles", nbuf, expb);
        chk(nbad == 0, "R4 buffer word and enable", nbad, 0);
      end

    // R6: inner loop 13..14 (count 2) inside outer 11..20 (count 1)
    nev = 0;
    add_ev(12, 1, 14, 2, 1'b0);
    exec(10, 20, 1, 21);
    chk(hits[14] == 6, "R6 inner passes", hits[14], 6);
    chk(hits[20] == 2, "R6 outer passes", hits[20], 2);
    chk(nbuf == 8, "R6 only inner replayed", nbuf, 8);
    chk(nbad == 0, "R6 buffer word", nbad, 0);

    // R7: third nested start with two loops saved is ignored
    nev = 0;
    add_ev(51, 1, 58, 0, 1'b0);
    add_ev(52, 1, 56, 1, 1'b0);
    add_ev(53, 1, 54, 1, 1'b0);
    exec(50, 60, 0, 61);
    chk(hits[54] == 2, "R7 ignored start", hits[54], 2);
    chk(hits[56] == 2, "R7 middle loop passes", hits[56], 2);
    chk(hits[58] == 1 && hits[60] == 1, "R7 outer loops once", hits[58] + hits[60], 2);
    chk(nbuf == 4, "R7 middle loop replay", nbuf, 4);

    // R8: explicit push then pop inside the first pass
    nev = 0;
    add_ev(41, 2, 0, 0, 1'b1);
    add_ev(42, 3, 0, 0, 1'b1);
    exec(40, 44, 2, 45);
    chk(hits[44] == 3, "R8 passes after push/pop", hits[44], 3);
    chk(nbuf == 4, "R8 refill then one replay", nbuf, 4);

    // R9: pop with empty stack ignored
    nev = 0;
    add_ev(71, 3, 0, 0, 1'b1);
    exec(70, 72, 1, 73);
    chk(hits[72] == 2, "R9 passes", hits[72], 2);
    chk(nbuf == 2, "R9 replay kept", nbuf, 2);

    // R10: start on the end address of a running loop takes priority over the wrap
    nev = 0;
    add_ev(84, 1, 86, 0, 1'b1);
    exec(80, 84, 3, 87);
    chk(hits[84] == 1 && hits[86] == 1, "R10 start beats wrap", hits[84] + hits[86], 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule